// File: doc/BRIEF.md
# Configurable Logic Cell with Serial Configuration

This block is one logic cell of a programmable fabric. Two four-input lookup tables, F and G, each evaluate any Boolean function of their own four inputs. A third, three-input table H takes both of their results plus a control input. With it the cell can act as any function of five inputs, as two independent four-input functions, or as certain functions of up to nine inputs. Programmable multiplexers route these results to two combinational outputs and to two flip-flops. Each flip-flop has a configurable clock enable and a synchronous set or reset.

All behaviour is set by a configuration vector held in a shift chain. It is loaded one bit per clock before operation. It can be read back serially for debug by feeding the serial output into the serial input, which rotates the chain without changing it. A level input marks configuration as complete. Until it is high, every output of the cell is held at zero.

Top module: `clb_cell`

## Requirements
- R1: With both output selects at 0, `x_out` equals bit `f_in` of the F table (configuration bits [15:0]) and `y_out` equals bit `g_in` of the G table (bits [31:16]). The two functions are independent.
- R2: The H table (bits [39:32]) is indexed by {`ctl_h`, G result, F result}, with the F result as the least significant bit. With F and G fed the same four signals, any function of those four signals plus `ctl_h` can be realised.
- R3: Bit 40 selects the H result for `x_out` (1) or the F result (0). Bit 41 does the same for `y_out`, choosing between H and the G result.
- R4: Bits [43:42] pick the data of the X flip-flop and bits [45:44] that of the Y flip-flop: 0 F result, 1 G result, 2 H result, 3 `ctl_din`. `xq_out`/`yq_out` show the selected value one clock edge after it was presented.
- R5: When a flip-flop's enable-use bit is 1 (bit 46 for X, bit 47 for Y), the flip-flop loads only on edges where `ctl_en` is 1 and otherwise holds. When the bit is 0, it loads on every edge.
- R6: When a flip-flop's set/reset-use bit is 1 (bit 48 for X, bit 50 for Y), `ctl_sr`=1 forces it synchronously to its polarity bit (bit 49 for X, bit 51 for Y; 1 = set, 0 = reset), overriding the enable. When the use bit is 0, `ctl_sr` has no effect.
- R7: While `cfg_done` is 0, `x_out` and `y_out` are 0 and both flip-flops are cleared on the next edge.
- R8: With `cfg_shift_en`=1 and `cfg_done`=0, each edge shifts the chain one place toward bit 0 and places `cfg_din` in the top bit. The first bit shifted in of 52 ends at bit 0.
- R9: `cfg_dout` presents configuration bit 0. Shifting 52 times with `cfg_din` tied to `cfg_dout` reads out bits 0 to 51 in order and leaves the configuration unchanged.
- R10: While `cfg_done` is 1, `cfg_shift_en` is ignored and the configuration does not change.
- R11: After reset, the configuration is all zero and all outputs, including `cfg_dout`, are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_shift_en | input | 1 | Shift the configuration chain one place |
| cfg_din | input | 1 | Serial configuration input |
| cfg_done | input | 1 | Configuration complete; enables the outputs |
| cfg_dout | output | 1 | Serial configuration output (bit 0) |
| f_in | input | 4 | F table inputs |
| g_in | input | 4 | G table inputs |
| ctl_h | input | 1 | Third input of the H table |
| ctl_din | input | 1 | Direct flip-flop data |
| ctl_en | input | 1 | Flip-flop clock enable |
| ctl_sr | input | 1 | Flip-flop synchronous set/reset |
| x_out | output | 1 | Combinational output X |
| y_out | output | 1 | Combinational output Y |
| xq_out | output | 1 | Registered output X |
| yq_out | output | 1 | Registered output Y |

## Verification
The bench sweeps every input combination of random truth tables, so a table indexed in the wrong bit order or with F and G swapped gives wrong outputs on about half the patterns. A five-input function is built from a fixed H pattern, and random nine-input patterns are applied. These catch an H index that puts `ctl_h` or the G result in the wrong position. The flip-flop tests mix enable, set/reset and both polarities so that a design where the enable blocks set/reset, or the polarity is inverted, shows a wrong registered value. Readback and shifting while done catch a chain that reverses order, loses the rotated bit, or keeps shifting during operation.

// File: rtl/clb_pkg.sv
package clb_pkg;
  localparam int LUT_K  = 4;
  localparam int H_K    = 3;
  localparam int LUT_TT = 1 << LUT_K;
  localparam int H_TT   = 1 << H_K;

  typedef enum logic [1:0] {
    SRC_F   = 2'd0,
    SRC_G   = 2'd1,
    SRC_H   = 2'd2,
    SRC_DIR = 2'd3
  } ff_src_e;

  // Packed from MSB down; f_tt occupies the lowest bits.
  typedef struct packed {
    logic              yq_sr_set;
    logic              yq_sr_use;
    logic              xq_sr_set;
    logic              xq_sr_use;
    logic              yq_ce_use;
    logic              xq_ce_use;
    ff_src_e           yq_src;
    ff_src_e           xq_src;
    logic              y_sel;
    logic              x_sel;
    logic [H_TT-1:0]   h_tt;
    logic [LUT_TT-1:0] g_tt;
    logic [LUT_TT-1:0] f_tt;
  } clb_cfg_t;

  localparam int CFG_W = $bits(clb_cfg_t);
endpackage

// File: rtl/clb_lut.sv
module clb_lut #(
  parameter int K = 4
) (
  input  logic [(1<<K)-1:0] tt,
  input  logic [K-1:0]      sel,
  output logic              out
);
  assign out = tt[sel];
endmodule

// File: rtl/clb_cfg_chain.sv
module clb_cfg_chain #(
  parameter int W = 52
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         done,
  input  logic         din,
  output logic [W-1:0] cfg_q,
  output logic         dout
);
  logic [W-1:0] cfg_d;
  logic         shift_ok;

  assign shift_ok = shift_en && !done;

  always_comb begin
    cfg_d = cfg_q;
    if (shift_ok) cfg_d = {din, cfg_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_q <= '0;
    else if (shift_ok) cfg_q <= cfg_d;
  end

  assign dout = cfg_q[0];

  // R8: serial bit lands on top, rest moves down
  p_shift_in_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !done) |=> (cfg_q[W-1] == $past(din)) && (cfg_q[W-2:0] == $past(cfg_q[W-1:1])));

  // R10: configuration frozen once done
  p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(cfg_q));
endmodule

// File: rtl/clb_ff.sv
module clb_ff (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  input  logic d,
  input  logic en,
  input  logic sr,
  input  logic ce_use,
  input  logic sr_use,
  input  logic sr_set,
  output logic q
);
  logic q_d;
  logic upd;
  logic sr_hit;

  assign sr_hit = sr_use && sr;

  always_comb begin
    q_d = q;
    upd = 1'b0;
    if (!done) begin
      q_d = 1'b0;
      upd = 1'b1;
    end else if (sr_hit) begin
      q_d = sr_set;
      upd = 1'b1;
    end else if (!ce_use || en) begin
      q_d = d;
      upd = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (upd) q <= q_d;
  end

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (q == 1'b0));

  p_sr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && sr_hit) |=> (q == $past(sr_set)));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !sr_hit && ce_use && !en) |=> $stable(q));

  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !sr_hit && (!ce_use || en)) |=> (q == $past(d)));
endmodule

// File: rtl/clb_cell.sv
module clb_cell
  import clb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_shift_en,
  input  logic             cfg_din,
  input  logic             cfg_done,
  output logic             cfg_dout,
  input  logic [LUT_K-1:0] f_in,
  input  logic [LUT_K-1:0] g_in,
  input  logic             ctl_h,
  input  logic             ctl_din,
  input  logic             ctl_en,
  input  logic             ctl_sr,
  output logic             x_out,
  output logic             y_out,
  output logic             xq_out,
  output logic             yq_out
);
  logic             rst_meta;
  logic             rst_s;
  logic [CFG_W-1:0] cfg_q;
  clb_cfg_t         cfg;
  logic             f_o;
  logic             g_o;
  logic             h_o;
  logic [1:0]       q_v;
  ff_src_e          src_a   [2];
  logic             ce_a    [2];
  logic             sru_a   [2];
  logic             srs_a   [2];

  // reset asserted asynchronously, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  clb_cfg_chain #(.W(CFG_W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_s),
    .shift_en (cfg_shift_en),
    .done     (cfg_done),
    .din      (cfg_din),
    .cfg_q    (cfg_q),
    .dout     (cfg_dout)
  );

  assign cfg = clb_cfg_t'(cfg_q);

  clb_lut #(.K(LUT_K)) u_lut_f (.tt(cfg.f_tt), .sel(f_in), .out(f_o));
  clb_lut #(.K(LUT_K)) u_lut_g (.tt(cfg.g_tt), .sel(g_in), .out(g_o));
  clb_lut #(.K(H_K))   u_lut_h (.tt(cfg.h_tt), .sel({ctl_h, g_o, f_o}), .out(h_o));

  assign x_out = cfg_done & (cfg.x_sel ? h_o : f_o);
  assign y_out = cfg_done & (cfg.y_sel ? h_o : g_o);

  assign src_a[0] = cfg.xq_src;
  assign src_a[1] = cfg.yq_src;
  assign ce_a[0]  = cfg.xq_ce_use;
  assign ce_a[1]  = cfg.yq_ce_use;
  assign sru_a[0] = cfg.xq_sr_use;
  assign sru_a[1] = cfg.yq_sr_use;
  assign srs_a[0] = cfg.xq_sr_set;
  assign srs_a[1] = cfg.yq_sr_set;

  for (genvar gi = 0; gi < 2; gi++) begin : g_ff
    logic d_sel;
    always_comb begin
      case (src_a[gi])
        SRC_F:   d_sel = f_o;
        SRC_G:   d_sel = g_o;
        SRC_H:   d_sel = h_o;
        default: d_sel = ctl_din;
      endcase
    end

    clb_ff u_ff (
      .clk    (clk),
      .rst_n  (rst_s),
      .done   (cfg_done),
      .d      (d_sel),
      .en     (ctl_en),
      .sr     (ctl_sr),
      .ce_use (ce_a[gi]),
      .sr_use (sru_a[gi]),
      .sr_set (srs_a[gi]),
      .q      (q_v[gi])
    );
  end

  assign xq_out = q_v[0];
  assign yq_out = q_v[1];

  // R11: registered outputs low while reset is held internally
  p_reset_q_r11: assert property (@(posedge clk)
    !rst_s |-> (q_v == 2'b00));
endmodule

// File: tb/clb_cell_bench.sv
module clb_cell_bench;
  import clb_pkg::*;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_shift_en, cfg_din, cfg_done, cfg_dout;
  logic [LUT_K-1:0] f_in, g_in;
  logic             ctl_h, ctl_din, ctl_en, ctl_sr;
  logic             x_out, y_out, xq_out, yq_out;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  clb_cell u_clb_cell (
    .clk(clk), .rst_n(rst_n), .cfg_shift_en(cfg_shift_en), .cfg_din(cfg_din),
    .cfg_done(cfg_done), .cfg_dout(cfg_dout), .f_in(f_in), .g_in(g_in),
    .ctl_h(ctl_h), .ctl_din(ctl_din), .ctl_en(ctl_en), .ctl_sr(ctl_sr),
    .x_out(x_out), .y_out(y_out), .xq_out(xq_out), .yq_out(yq_out)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic clb_cfg_t rand_cfg();
    clb_cfg_t c;
    c = '0;
    c.f_tt = LUT_TT'($urandom);
    c.g_tt = LUT_TT'($urandom);
    c.h_tt = H_TT'($urandom);
    return c;
  endfunction

  function automatic logic h_of(clb_cfg_t c, logic [3:0] f, logic [3:0] g, logic h);
    return c.h_tt[{h, c.g_tt[g], c.f_tt[f]}];
  endfunction

  task automatic load_cfg(input clb_cfg_t c);
    logic [CFG_W-1:0] v;
    v = c;
    @(negedge clk);
    cfg_done = 1'b0;
    for (int i = 0; i < CFG_W; i++) begin
      @(negedge clk);
      cfg_shift_en = 1'b1;
      cfg_din      = v[i];
    end
    @(negedge clk);
    cfg_shift_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 x", x_out, 0);
    chk("R11 y", y_out, 0);
    chk("R11 xq", xq_out, 0);
    chk("R11 yq", yq_out, 0);
    chk("R11 dout", cfg_dout, 0);
  endtask

  task automatic t_two_funcs();
    for (int k = 0; k < 3; k++) begin
      clb_cfg_t c;
      c = rand_cfg();
      load_cfg(c);
      @(negedge clk);
      cfg_done = 1'b1;
      for (int p = 0; p < 256; p++) begin
        @(negedge clk);
        f_in = p[3:0];
        g_in = p[7:4];
        ctl_h = p[0];
        #1;
        chk("R1 x=F", x_out, c.f_tt[p[3:0]]);
        chk("R1 y=G", y_out, c.g_tt[p[7:4]]);
      end
    end
  endtask

  task automatic t_five();
    clb_cfg_t c;
    logic [31:0] fn;
    fn = $urandom;
    c = '0;
    c.f_tt  = fn[15:0];
    c.g_tt  = fn[31:16];
    c.h_tt  = 8'hCA;
    c.x_sel = 1'b1;
    c.y_sel = 1'b1;
    load_cfg(c);
    @(negedge clk);
    cfg_done = 1'b1;
    for (int p = 0; p < 32; p++) begin
      @(negedge clk);
      f_in  = p[3:0];
      g_in  = p[3:0];
      ctl_h = p[4];
      #1;
      chk("R2 five-input x", x_out, fn[p]);
      chk("R3 y selects H", y_out, fn[p]);
    end
  endtask

  task automatic t_nine();
    clb_cfg_t c;
    c = rand_cfg();
    c.x_sel = 1'b1;
    load_cfg(c);
    @(negedge clk);
    cfg_done = 1'b1;
    for (int p = 0; p < 64; p++) begin
      @(negedge clk);
      f_in  = 4'($urandom);
      g_in  = 4'($urandom);
      ctl_h = 1'($urandom);
      #1;
      chk("R2 nine-input x=H", x_out, h_of(c, f_in, g_in, ctl_h));
      chk("R3 y=G", y_out, c.g_tt[g_in]);
    end
  endtask

  task automatic t_ff_src();
    for (int k = 0; k < 2; k++) begin
      clb_cfg_t c;
      c = rand_cfg();
      c.xq_src = (k == 0) ? SRC_DIR : SRC_F;
      c.yq_src = (k == 0) ? SRC_H : SRC_G;
      load_cfg(c);
      for (int p = 0; p < 20; p++) begin
        logic ex, ey;
        @(negedge clk);
        cfg_done = 1'b1;
        f_in = 4'($urandom); g_in = 4'($urandom);
        ctl_h = 1'($urandom); ctl_din = 1'($urandom);
        ctl_en = 1'($urandom); ctl_sr = 1'($urandom);
        ex = (k == 0) ? ctl_din : c.f_tt[f_in];
        ey = (k == 0) ? h_of(c, f_in, g_in, ctl_h) : c.g_tt[g_in];
        @(posedge clk);
        #1;
        chk("R4 xq source", xq_out, ex);
        chk("R4 yq source", yq_out, ey);
      end
    end
  endtask

  task automatic t_enable();
    clb_cfg_t c;
    logic ex;
    c = rand_cfg();
    c.xq_src = SRC_DIR; c.yq_src = SRC_DIR;
    c.xq_ce_use = 1'b1;
    load_cfg(c);
    ex = 1'b0;
    for (int p = 0; p < 30; p++) begin
      @(negedge clk);
      cfg_done = 1'b1;
      ctl_sr = 1'b0;
      ctl_en = 1'($urandom);
      ctl_din = 1'($urandom);
      if (ctl_en) ex = ctl_din;
      @(posedge clk);
      #1;
      chk("R5 xq enabled", xq_out, ex);
      chk("R5 yq free-running", yq_out, ctl_din);
    end
  endtask

  task automatic t_sr();
    clb_cfg_t c;
    logic ex;
    c = rand_cfg();
    c.xq_src = SRC_DIR; c.yq_src = SRC_DIR;
    c.xq_ce_use = 1'b1;
    c.xq_sr_use = 1'b1; c.xq_sr_set = 1'b1;
    c.yq_sr_use = 1'b1; c.yq_sr_set = 1'b0;
    load_cfg(c);
    ex = 1'b0;
    for (int p = 0; p < 40; p++) begin
      @(negedge clk);
      cfg_done = 1'b1;
      ctl_en = 1'($urandom); ctl_din = 1'($urandom); ctl_sr = 1'($urandom);
      if (ctl_sr) ex = 1'b1;
      else if (ctl_en) ex = ctl_din;
      @(posedge clk);
      #1;
      chk("R6 xq set", xq_out, ex);
      chk("R6 yq reset", yq_out, ctl_sr ? 1'b0 : ctl_din);
    end
    c.xq_sr_use = 1'b0; c.yq_sr_use = 1'b0; c.xq_ce_use = 1'b0;
    load_cfg(c);
    for (int p = 0; p < 20; p++) begin
      @(negedge clk);
      cfg_done = 1'b1;
      ctl_din = 1'($urandom); ctl_sr = 1'b1;
      @(posedge clk);
      #1;
      chk("R6 sr unused x", xq_out, ctl_din);
      chk("R6 sr unused y", yq_out, ctl_din);
    end
  endtask

  task automatic t_done();
    clb_cfg_t c;
    c = '0;
    c.f_tt = '1; c.g_tt = '1;
    c.xq_src = SRC_DIR; c.yq_src = SRC_F;
    load_cfg(c);
    @(negedge clk);
    f_in = 4'd5; g_in = 4'd9; ctl_din = 1'b1; ctl_sr = 1'b0; ctl_en = 1'b1;
    #1;
    chk("R7 x low before done", x_out, 0);
    chk("R7 y low before done", y_out, 0);
    cfg_done = 1'b1;
    @(posedge clk);
    #1;
    chk("R7 xq after done", xq_out, 1);
    chk("R7 yq after done", yq_out, 1);
    @(negedge clk);
    cfg_done = 1'b0;
    #1;
    chk("R7 x gated", x_out, 0);
    chk("R7 y gated", y_out, 0);
    @(posedge clk);
    #1;
    chk("R7 xq cleared", xq_out, 0);
    chk("R7 yq cleared", yq_out, 0);
  endtask

  task automatic readback(output logic [CFG_W-1:0] rb);
    @(negedge clk);
    cfg_done = 1'b0;
    for (int i = 0; i < CFG_W; i++) begin
      @(negedge clk);
      rb[i]        = cfg_dout;
      cfg_din      = cfg_dout;
      cfg_shift_en = 1'b1;
    end
    @(negedge clk);
    cfg_shift_en = 1'b0;
  endtask

  task automatic t_readback();
    clb_cfg_t c;
    logic [CFG_W-1:0] v, rb;
    c = rand_cfg();
    c.xq_src = SRC_H;
    c.y_sel = 1'b1;
    v = c;
    load_cfg(c);
    #1;
    chk("R8 first bit at position 0", cfg_dout, v[0]);
    readback(rb);
    chk("R9 readback low", rb[31:0], v[31:0]);
    chk("R9 readback high", 64'(rb[CFG_W-1:32]), 64'(v[CFG_W-1:32]));
    @(negedge clk);
    cfg_done = 1'b1;
    for (int p = 0; p < 16; p++) begin
      @(negedge clk);
      f_in = p[3:0]; g_in = 4'($urandom); ctl_h = 1'($urandom);
      #1;
      chk("R9 config kept x", x_out, c.f_tt[p[3:0]]);
      chk("R9 config kept y", y_out, h_of(c, f_in, g_in, ctl_h));
    end
  endtask

  task automatic t_frozen();
    clb_cfg_t c;
    logic [CFG_W-1:0] v, rb;
    c = rand_cfg();
    v = c;
    load_cfg(c);
    @(negedge clk);
    cfg_done = 1'b1;
    for (int p = 0; p < 12; p++) begin
      @(negedge clk);
      cfg_shift_en = 1'b1;
      cfg_din = 1'($urandom);
    end
    @(negedge clk);
    cfg_shift_en = 1'b0;
    for (int p = 0; p < 16; p++) begin
      @(negedge clk);
      f_in = p[3:0]; g_in = 4'(15 - p);
      #1;
      chk("R10 x unchanged", x_out, c.f_tt[p[3:0]]);
      chk("R10 y unchanged", y_out, c.g_tt[4'(15 - p)]);
    end
    readback(rb);
    chk("R10 readback low", rb[31:0], v[31:0]);
    chk("R10 readback high", 64'(rb[CFG_W-1:32]), 64'(v[CFG_W-1:32]));
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_shift_en = 1'b0; cfg_din = 1'b0; cfg_done = 1'b0;
    f_in = '0; g_in = '0; ctl_h = 1'b0; ctl_din = 1'b0; ctl_en = 1'b0; ctl_sr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_two_funcs();
    t_five();
    t_nine();
    t_ff_src();
    t_enable();
    t_sr();
    t_done();
    t_readback();
    t_frozen();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule